// File: doc/BRIEF.md
# Streaming 3x3 Image Convolution Filter

This block filters a greyscale image that arrives as a raster-order stream. Each pixel comes in over a ready/valid handshake, and a frame-start flag marks the first pixel of a frame. Two line buffers hold the two rows above the incoming pixel. A 3x3 window slides across the image, and nine multipliers apply a signed fixed-point kernel to it in parallel. The filtered stream leaves on a second ready/valid interface. It carries one output pixel for every input pixel, together with its own frame-start and line-end flags.

The kernel comes either from a bank of nine coefficients that can be written at run time or from one of three built-in presets: blur, sharpen and outline. The image width and height are configuration inputs, up to the parameter limits. The geometry and the kernel choice are both captured when a frame starts. After the last input pixel of a frame, the block refuses input for a short drain period. During that period it pushes out the last outputs, which are held back by one line and one pixel.

Top module: `conv3x3_stream`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: An interior output pixel at row r, column c is computed as follows. Take S = sum of p(r-1+i, c-1+j) * k[3i+j] over i,j in 0..2, where row i=0 is the upper row and j=0 is the left column, and k is signed with 4 fractional bits. The output is then (S + 8) shifted arithmetically right by 4.
- R3: Every output pixel in the first or last row, or in the first or last column, is 0.
- R4: `presetSel` selects the kernel. 1 is blur (corner 1, edge 2, centre 4). 2 is sharpen (corner 0, edge -16, centre 80). 3 is outline (all neighbours -16, centre 128). 0 selects the user coefficient bank.
- R5: A cycle with `coefWrEn` high writes the 10-bit signed value `coefWrData` into user coefficient k[`coefWrIdx`], for indexes 0..8.
- R6: The kernel is captured when the frame-start pixel is accepted. Preset changes and coefficient writes made during a frame do not affect that frame; they apply from the next frame start.
- R7: While no frame is active, pixels without `inSof` are accepted and dropped. A pixel with `inSof` starts a frame and captures `widthCfg` and `heightCfg`. Later changes to these inputs do not affect the running frame.
- R8: A W x H frame yields exactly W*H output pixels. `outSof` is set on the first of them only, and `outEol` is set on the last pixel of each row.
- R9: With no stalls, output pixel j is presented so that it is consumed 3 cycles after input pixel j+W+1 is accepted. The final output of a frame is consumed W+4 cycles after the last input is accepted, because `inReady` is held low for W+1 drain cycles.
- R10: While `outValid` is high and `outReady` is low, the output pixel and flags hold still. No pixel is lost or duplicated under any pattern of input gaps and output stalls.
- R11: With `outReady` held high and input always valid, all W*H pixels of a frame are accepted on consecutive cycles.
- R12: Results below 0 are output as 0, and results above 255 are output as 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Block accepts an input pixel |
| inPixel | input | PIX_W | Unsigned input pixel |
| inSof | input | 1 | Marks the first pixel of a frame |
| presetSel | input | 2 | Kernel choice: 0 user, 1 blur, 2 sharpen, 3 outline |
| coefWrEn | input | 1 | User coefficient write strobe |
| coefWrIdx | input | 4 | User coefficient index, 0..8 |
| coefWrData | input | COEF_W | Signed coefficient, 4 fractional bits |
| widthCfg | input | clog2(MAX_W+1) | Image width, at least 3 |
| heightCfg | input | clog2(MAX_H+1) | Image height, at least 3 |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream accepts the output pixel |
| outPixel | output | PIX_W | Filtered pixel |
| outSof | output | 1 | First output pixel of a frame |
| outEol | output | 1 | Last output pixel of a row |

## Verification
The risky overlap is an input pixel being accepted, which shifts the window and writes both line buffers, in the same cycle that the downstream stall freezes the product and output stages. Both sides are gated by one shared advance condition, so a mistake there shows up as a lost, repeated or misplaced pixel. The bench provokes this overlap by combining pseudo-random input gaps with pseudo-random `outReady` drops over a whole frame that uses a user kernel. It judges the result by comparing every output pixel and flag against an arithmetic model of the frame and by requiring the exact output count. A second overlap is the frame-start kernel capture racing with preset and coefficient changes. The bench tests it by changing both in the middle of a frame.

// File: rtl/conv3x3_pkg.sv
package conv3x3_pkg;

  // Preset kernels are expressed with this many fractional bits.
  localparam int CONV_FRAC_W = 4;
  localparam int TAPS        = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } ctrlState_e;

  // Per-cycle strobes from the control to the datapath.
  typedef struct packed {
    logic step;        // advance window and line buffers by one position
    logic emit;        // this step produces an output pixel
    logic border;      // the produced pixel lies on the border ring
    logic frameSof;    // the produced pixel is the first of its frame
    logic lineEol;     // the produced pixel closes a row
    logic loadKernel;  // capture the kernel for a new frame
    logic flushing;    // step carries no real input pixel
  } convStrobes_t;

  // Preset weight for tap idx (row-major, upper-left first).
  function automatic int presetWeight(logic [1:0] sel, int idx);
    bit isCentre;
    bit isCorner;
    isCentre = (idx == 4);
    isCorner = (idx == 0) || (idx == 2) || (idx == 6) || (idx == 8);
    case (sel)
      2'd1:    return isCentre ? 4   : (isCorner ? 1 : 2);
      2'd2:    return isCentre ? 80  : (isCorner ? 0 : -16);
      2'd3:    return isCentre ? 128 : -16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/conv3x3_ctrl.sv
module conv3x3_ctrl
  import conv3x3_pkg::*;
#(
  parameter int MAX_W = 512,
  parameter int MAX_H = 512
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic                         inSof,
  input  logic [$clog2(MAX_W+1)-1:0]   widthCfg,
  input  logic [$clog2(MAX_H+1)-1:0]   heightCfg,
  input  logic                         pipeFree,
  output logic                         inReady,
  output logic [$clog2(MAX_W)-1:0]     lbCol,
  output convStrobes_t                 strobes
);

  localparam int WD_W  = $clog2(MAX_W + 1);
  localparam int HD_W  = $clog2(MAX_H + 1);
  localparam int COL_W = $clog2(MAX_W);

  ctrlState_e      state;
  logic [WD_W-1:0] widthR, inCol, outCol, flushCnt;
  logic [HD_W-1:0] heightR, inRow, outRow;

  logic            idleStart, step, emit, lastPixel;
  logic [WD_W-1:0] colNow, lastCol;
  logic [HD_W-1:0] rowNow;

  always_comb begin
    idleStart = (state == ST_IDLE) && inValid && inSof && pipeFree;
    inReady   = pipeFree && (state != ST_FLUSH);
    step      = idleStart ||
                (pipeFree && (((state == ST_RUN) && inValid) || (state == ST_FLUSH)));
    colNow    = idleStart ? '0 : inCol;
    rowNow    = idleStart ? '0 : inRow;
    lastCol   = (state == ST_IDLE) ? (widthCfg - 1'b1) : (widthR - 1'b1);
    emit      = step && ((state == ST_FLUSH) || (rowNow > 1) ||
                         ((rowNow == 1) && (colNow != '0)));
    lastPixel = (state == ST_RUN) && (inRow == heightR - 1'b1) &&
                (inCol == widthR - 1'b1);
  end

  assign lbCol = colNow[COL_W-1:0];

  always_comb begin
    strobes            = '0;
    strobes.step       = step;
    strobes.emit       = emit;
    strobes.border     = (outRow == '0) || (outRow == heightR - 1'b1) ||
                         (outCol == '0) || (outCol == widthR - 1'b1);
    strobes.frameSof   = (outRow == '0) && (outCol == '0);
    strobes.lineEol    = (outCol == widthR - 1'b1);
    strobes.loadKernel = idleStart;
    strobes.flushing   = (state == ST_FLUSH);
  end

  // Input-side position: column of the newest window column.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCol <= '0;
      inRow <= '0;
    end else if (step) begin
      if (colNow == lastCol) begin
        inCol <= '0;
        inRow <= rowNow + 1'b1;
      end else begin
        inCol <= colNow + 1'b1;
        inRow <= rowNow;
      end
    end
  end

  // Output-side position and frame sequencing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      widthR   <= '0;
      heightR  <= '0;
      outCol   <= '0;
      outRow   <= '0;
      flushCnt <= '0;
    end else begin
      if (emit) begin
        if (outCol == widthR - 1'b1) begin
          outCol <= '0;
          outRow <= outRow + 1'b1;
        end else begin
          outCol <= outCol + 1'b1;
        end
      end
      case (state)
        ST_IDLE: if (idleStart) begin
          widthR  <= widthCfg;
          heightR <= heightCfg;
          outCol  <= '0;
          outRow  <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: if (step && lastPixel) begin
          flushCnt <= '0;
          state    <= ST_FLUSH;
        end
        ST_FLUSH: if (step) begin
          if (flushCnt == widthR) state <= ST_IDLE;
          else                    flushCnt <= flushCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: the drain never runs longer than W+1 steps.
  p_flush_bounded_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH) |-> (flushCnt <= widthR));

  // R8: inside a frame, the output position never leaves the image.
  p_out_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> ((outRow < heightR) && (outCol < widthR)));

  // R7: no output is produced outside a frame.
  p_no_emit_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> !(strobes.emit && $past(state == ST_IDLE) && (state == ST_IDLE)));

endmodule

// File: rtl/conv3x3_datapath.sv
module conv3x3_datapath
  import conv3x3_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 10,
  parameter int MAX_W  = 512
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  convStrobes_t              ctl,
  input  logic [$clog2(MAX_W)-1:0]  lbCol,
  input  logic [PIX_W-1:0]          inPixel,
  input  logic [1:0]                presetSel,
  input  logic                      coefWrEn,
  input  logic [3:0]                coefWrIdx,
  input  logic [COEF_W-1:0]         coefWrData,
  input  logic                      outReady,
  output logic                      pipeFree,
  output logic                      outValid,
  output logic [PIX_W-1:0]          outPixel,
  output logic                      outSof,
  output logic                      outEol
);

  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int ACC_W  = PROD_W + 4;
  localparam logic signed [ACC_W-1:0] ROUND_K = ACC_W'(1 << (CONV_FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] SAT_HI  = ACC_W'((1 << PIX_W) - 1);

  logic en;
  assign en       = !outValid || outReady;
  assign pipeFree = en;

  // Coefficient storage: user bank and the kernel captured per frame.
  logic [TAPS-1:0][COEF_W-1:0] userBank, kern;

  always_ff @(posedge clk) begin
    if (!rstN) userBank <= '0;
    else if (coefWrEn && (coefWrIdx < 4'(TAPS))) userBank[coefWrIdx] <= coefWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kern <= '0;
    end else if (ctl.loadKernel) begin
      for (int t = 0; t < TAPS; t++)
        kern[t] <= (presetSel == 2'd0) ? userBank[t]
                                       : COEF_W'(presetWeight(presetSel, t));
    end
  end

  // Line buffers: lineUp1 holds the row above the newest pixel, lineUp2 two above.
  logic [PIX_W-1:0] lineUp1 [MAX_W];
  logic [PIX_W-1:0] lineUp2 [MAX_W];
  logic [PIX_W-1:0] newPix;

  assign newPix = ctl.flushing ? '0 : inPixel;

  always_ff @(posedge clk) begin
    if (ctl.step) begin
      lineUp2[lbCol] <= lineUp1[lbCol];
      lineUp1[lbCol] <= newPix;
    end
  end

  // 3x3 window, row 0 = oldest line, column 2 = newest column.
  logic [2:0][2:0][PIX_W-1:0] win;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      win <= '0;
    end else if (ctl.step) begin
      for (int r = 0; r < 3; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
      end
      win[0][2] <= lineUp2[lbCol];
      win[1][2] <= lineUp1[lbCol];
      win[2][2] <= newPix;
    end
  end

  logic [PIX_W-1:0] tapPix [TAPS];
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapPix[t] = win[t / 3][t % 3];
  end

  // Stage A: window valid and position tags.
  logic aValid, aBorder, aSof, aEol;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid <= 1'b0; aBorder <= 1'b0; aSof <= 1'b0; aEol <= 1'b0;
    end else if (en) begin
      aValid  <= ctl.emit;
      aBorder <= ctl.border;
      aSof    <= ctl.frameSof;
      aEol    <= ctl.lineEol;
    end
  end

  // Stage B: nine parallel products.
  logic signed [PROD_W-1:0] prod [TAPS];
  logic bValid, bBorder, bSof, bEol;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < TAPS; t++) prod[t] <= '0;
      bValid <= 1'b0; bBorder <= 1'b0; bSof <= 1'b0; bEol <= 1'b0;
    end else if (en) begin
      for (int t = 0; t < TAPS; t++)
        prod[t] <= $signed({1'b0, tapPix[t]}) * $signed(kern[t]);
      bValid  <= aValid;
      bBorder <= aBorder;
      bSof    <= aSof;
      bEol    <= aEol;
    end
  end

  // Adder tree, rounding and saturation.
  logic signed [ACC_W-1:0] accSum, rounded, scaled;
  logic [PIX_W-1:0]        satPix;
  always_comb begin
    accSum = '0;
    for (int t = 0; t < TAPS; t++) accSum = accSum + ACC_W'(prod[t]);
    rounded = accSum + ROUND_K;
    scaled  = rounded >>> CONV_FRAC_W;
    if (scaled < 0)           satPix = '0;
    else if (scaled > SAT_HI) satPix = '1;
    else                      satPix = scaled[PIX_W-1:0];
  end

  // Stage C: output register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; outPixel <= '0; outSof <= 1'b0; outEol <= 1'b0;
    end else if (en) begin
      outValid <= bValid;
      outPixel <= bBorder ? '0 : satPix;
      outSof   <= bSof;
      outEol   <= bEol;
    end
  end

  // R10: a stalled output holds its value and flags.
  p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outPixel) &&
                                 $stable(outSof) && $stable(outEol)));

  // R3: the frame corner and the last column are always zero.
  p_border_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outSof || outEol)) |-> (outPixel == '0));

  // R6: the kernel only changes after a frame-start capture.
  p_kernel_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadKernel |=> $stable(kern));

  // R9: a new output only appears from a filled product stage.
  p_rise_from_pipe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(bValid));

endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
  import conv3x3_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 10,
  parameter int MAX_W  = 512,
  parameter int MAX_H  = 512
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [PIX_W-1:0]            inPixel,
  input  logic                        inSof,
  input  logic [1:0]                  presetSel,
  input  logic                        coefWrEn,
  input  logic [3:0]                  coefWrIdx,
  input  logic [COEF_W-1:0]           coefWrData,
  input  logic [$clog2(MAX_W+1)-1:0]  widthCfg,
  input  logic [$clog2(MAX_H+1)-1:0]  heightCfg,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [PIX_W-1:0]            outPixel,
  output logic                        outSof,
  output logic                        outEol
);

  localparam int COL_W = $clog2(MAX_W);

  convStrobes_t     strobes;
  logic [COL_W-1:0] lbCol;
  logic             pipeFree;

  conv3x3_ctrl #(
    .MAX_W (MAX_W),
    .MAX_H (MAX_H)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSof     (inSof),
    .widthCfg  (widthCfg),
    .heightCfg (heightCfg),
    .pipeFree  (pipeFree),
    .inReady   (inReady),
    .lbCol     (lbCol),
    .strobes   (strobes)
  );

  conv3x3_datapath #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W),
    .MAX_W  (MAX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (strobes),
    .lbCol      (lbCol),
    .inPixel    (inPixel),
    .presetSel  (presetSel),
    .coefWrEn   (coefWrEn),
    .coefWrIdx  (coefWrIdx),
    .coefWrData (coefWrData),
    .outReady   (outReady),
    .pipeFree   (pipeFree),
    .outValid   (outValid),
    .outPixel   (outPixel),
    .outSof     (outSof),
    .outEol     (outEol)
  );

endmodule

// File: tb/conv3x3_stream_test.sv
module conv3x3_stream_test;

  localparam int PW = 8;
  localparam int CW = 10;
  localparam int MW = 16;
  localparam int MH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                       rstN;
  logic                       inValid, inReady, inSof;
  logic [PW-1:0]              inPixel;
  logic [1:0]                 presetSel;
  logic                       coefWrEn;
  logic [3:0]                 coefWrIdx;
  logic [CW-1:0]              coefWrData;
  logic [$clog2(MW+1)-1:0]    widthCfg;
  logic [$clog2(MH+1)-1:0]    heightCfg;
  logic                       outValid, outReady, outSof, outEol;
  logic [PW-1:0]              outPixel;

  conv3x3_stream #(.PIX_W(PW), .COEF_W(CW), .MAX_W(MW), .MAX_H(MH)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPixel(inPixel), .inSof(inSof), .presetSel(presetSel),
    .coefWrEn(coefWrEn), .coefWrIdx(coefWrIdx), .coefWrData(coefWrData),
    .widthCfg(widthCfg), .heightCfg(heightCfg), .outValid(outValid),
    .outReady(outReady), .outPixel(outPixel), .outSof(outSof), .outEol(outEol)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  logic [15:0] lfsr = 16'hACE1;

  int img [16][16];
  int expK [9];
  int userK [9];
  int acc [256];
  int curW = 3, curH = 3, outIdx = 0;
  bit stallMode = 0, freeMode = 0;
  bit prevStall = 0;
  logic [PW-1:0] prevPix;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  task automatic check(bit ok, string req, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rawSum(int r, int c);
    int s = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        s += img[r-1+i][c-1+j] * expK[3*i+j];
    return (s + 8) >>> 4;
  endfunction

  always @(posedge clk) begin
    if (cyc == 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // Output monitor and downstream-ready generator.
  always @(negedge clk) begin
    outReady = stallMode ? (lfsr[3] | lfsr[7]) : 1'b1;
    #3;
    if (rstN) begin
      if (prevStall)
        check(outValid && (outPixel == prevPix), "R10 hold", outPixel, prevPix);
      prevStall = outValid && !outReady;
      prevPix   = outPixel;
      if (outValid && outReady) begin
        int j, r, c, e, raw;
        bit bord;
        j = outIdx;
        if (j >= curW * curH) begin
          check(0, "R8 extra output", j, curW * curH);
        end else begin
          r = j / curW;
          c = j % curW;
          bord = (r == 0) || (r == curH - 1) || (c == 0) || (c == curW - 1);
          raw  = bord ? 0 : rawSum(r, c);
          e    = (raw < 0) ? 0 : ((raw > 255) ? 255 : raw);
          if (bord)                        check(outPixel == e, "R3 border", outPixel, e);
          else if (raw < 0 || raw > 255)   check(outPixel == e, "R12 saturate", outPixel, e);
          else                             check(outPixel == e, "R2 interior", outPixel, e);
          check(outSof == (j == 0) && outEol == (c == curW - 1), "R8 flags",
                {outSof, outEol}, {(j == 0), (c == curW - 1)});
          if (freeMode && !bord)
            check(cyc + 1 == acc[j + curW + 1] + 3, "R9 latency", cyc + 1, acc[j + curW + 1] + 3);
          if (freeMode && j == curW * curH - 1)
            check(cyc + 1 == acc[j] + curW + 4, "R9 drain", cyc + 1, acc[j] + curW + 4);
        end
        outIdx++;
      end
    end
  end

  task automatic fillImg(int w, int h, int mode);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        case (mode)
          0:       img[r][c] = ((r * w + c) * 7) % 256;
          1:       img[r][c] = ((r + c) % 2) ? 255 : 0;
          default: img[r][c] = (r * 37 + c * 91 + 13 * r * c) % 256;
        endcase
  endtask

  task automatic setExpK(int p);
    for (int t = 0; t < 9; t++) begin
      bit cen, cor;
      cen = (t == 4);
      cor = (t == 0) || (t == 2) || (t == 6) || (t == 8);
      case (p)
        1:       expK[t] = cen ? 4 : (cor ? 1 : 2);
        2:       expK[t] = cen ? 80 : (cor ? 0 : -16);
        3:       expK[t] = cen ? 128 : -16;
        default: expK[t] = userK[t];
      endcase
    end
  endtask

  task automatic writeCoef(int idx, int val);
    @(negedge clk);
    coefWrEn   = 1'b1;
    coefWrIdx  = 4'(idx);
    coefWrData = CW'(val);
    @(negedge clk);
    coefWrEn   = 1'b0;
    userK[idx] = val;
  endtask

  task automatic sendFrame(int w, int h, bit gaps, int midAt);
    for (int k = 0; k < w * h; k++) begin
      bit done;
      done = 0;
      while (!done) begin
        @(negedge clk);
        coefWrEn = 1'b0;
        if (gaps && lfsr[5] && lfsr[9]) begin
          inValid = 1'b0;
        end else begin
          inValid = 1'b1;
          inPixel = PW'(img[k / w][k % w]);
          inSof   = (k == 0);
          #1;
          if (inReady) begin
            acc[k] = cyc + 1;
            done = 1;
          end
        end
      end
      if (k == midAt) begin
        // R6 / R7: mid-frame kernel and geometry changes must not apply
        presetSel  = 2'd1;
        coefWrEn   = 1'b1;
        coefWrIdx  = 4'd4;
        coefWrData = CW'(-40);
        widthCfg   = widthCfg + 2;
      end
    end
    @(negedge clk);
    inValid  = 1'b0;
    inSof    = 1'b0;
    coefWrEn = 1'b0;
  endtask

  task automatic runFrame(int w, int h, int preset, int mode, bit gaps, bit stall,
                          bit free, int midAt);
    int t;
    curW = w; curH = h; outIdx = 0;
    stallMode = stall; freeMode = free;
    widthCfg  = ($clog2(MW+1))'(w);
    heightCfg = ($clog2(MH+1))'(h);
    presetSel = 2'(preset);
    setExpK(preset);
    fillImg(w, h, mode);
    sendFrame(w, h, gaps, midAt);
    t = 0;
    while (outIdx < w * h && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    check(outIdx == w * h, "R8 count", outIdx, w * h);
    stallMode = 0;
    freeMode  = 0;
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; inSof = 1'b0; inPixel = '0;
    presetSel = 2'd0; coefWrEn = 1'b0; coefWrIdx = '0; coefWrData = '0;
    widthCfg = 5'd3; heightCfg = 5'd3;
    for (int t = 0; t < 9; t++) userK[t] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #4;
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(inReady == 1'b1, "R1 inReady", inReady, 1);

    // R4 blur, free flowing: R9 timing and R11 throughput
    runFrame(5, 4, 1, 0, 0, 0, 1, -1);
    check(acc[19] - acc[0] == 19, "R11 back-to-back", acc[19] - acc[0], 19);

    // R4 sharpen on a checkerboard drives R12 both ways
    runFrame(7, 5, 2, 1, 0, 0, 0, -1);

    // R4 outline on the smallest frame
    runFrame(3, 3, 3, 2, 0, 0, 0, -1);

    // R5 user kernel with R10 gaps and stalls
    writeCoef(0, -3); writeCoef(1, 7);   writeCoef(2, 0);
    writeCoef(3, 12); writeCoef(4, 20);  writeCoef(5, -5);
    writeCoef(6, 1);  writeCoef(7, -9);  writeCoef(8, 33);
    runFrame(8, 6, 0, 2, 1, 1, 0, -1);

    // R6: preset, coefficient and width change mid-frame
    runFrame(6, 5, 0, 0, 0, 0, 0, 10);
    userK[4] = -40;

    // R6 / R5: next frame picks up the coefficient written mid-frame
    runFrame(5, 5, 0, 2, 1, 1, 0, -1);

    // R7: a stray pixel outside a frame is taken and dropped
    @(negedge clk);
    inValid = 1'b1; inSof = 1'b0; inPixel = 8'd200;
    #1;
    check(inReady == 1'b1, "R7 idle accept", inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    runFrame(4, 3, 1, 2, 0, 0, 1, -1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule